// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the device side of a byte-wide flash memory and decides what a read returns. While the array is idle, a read passes the array byte through unchanged. While an internal program or erase is running, the read returns a status byte instead. That byte has three live bits:

- a bit that inverts on every read access, so the host can tell that the operation is still in progress;
- a bit that reports an operation that ran past its time limit;
- a bit that shows whether the sector-erase acceptance window has closed and the erase itself has begun.

Commands arrive already decoded, as single-cycle pulses. Each pulse comes on the cycle of the final write that completes its sequence. The array model reports completion on `alg_done`. An internal counter with parameterised limits stands in for the operation timer. A location that can never be programmed therefore ends in the failure state. That state holds until a reset command is written.

A sector erase does not start at once. It first opens an acceptance window of `WIN_CYCLES` cycles. During the window, further sector-erase commands add sectors to the erase set, and each one restarts the window. The set itself is visible on `erase_mask`.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_n` is low the block goes idle, `erase_mask` becomes 0 and `rd_data` equals `array_data`.
- R2: While idle, `rd_data` equals `array_data` combinationally.
- R3: During any operation (program, erase window, erase, failure), `rd_data[6]` reads 0 on the first access. It then inverts after every cycle with `rd_strobe` high. Cycles without `rd_strobe` leave it unchanged.
- R4: During an operation, `rd_data` bits 7, 4, 2, 1 and 0 read 0 regardless of `array_data`.
- R5: `cmd_prog` starts a program. An `alg_done` pulse ends it, and from the next cycle reads return array data again.
- R6: `cmd_chip_erase` starts an erase at once. `erase_mask` becomes all ones and `rd_data[3]` reads 1.
- R7: `cmd_sector_erase` opens the window. `erase_mask` gets bit `cmd_sector` set (bit i is sector i) and `rd_data[3]` reads 0. If no further sector command arrives, `rd_data[3]` reads 1 after `WIN_CYCLES` cycles.
- R8: A sector command inside the window is accepted, including one in its final cycle. It sets its mask bit and restarts the full window from that cycle.
- R9: While a program or erase is running, commands (sector, program, chip erase, reset) have no effect on `erase_mask` or on the status byte.
- R10: A program that has not seen `alg_done` `PROG_LIMIT` cycles after its command goes to failure. So does an erase that has not seen it `ERASE_LIMIT` cycles after it began. In failure `rd_data[5]` reads 1 and `rd_data[3]` reads 0.
- R11: In failure the toggle continues and `alg_done` and other commands are ignored. Only `cmd_reset` returns the block to idle array reads with `erase_mask` cleared.
- R12: If `alg_done` arrives in the very cycle the time limit is reached, completion wins and the block goes idle without failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_prog | input | 1 | Program command accepted (pulse) |
| cmd_chip_erase | input | 1 | Chip erase command accepted (pulse) |
| cmd_sector_erase | input | 1 | Sector erase command accepted (pulse) |
| cmd_sector | input | SECT_W | Sector addressed by `cmd_sector_erase` |
| cmd_reset | input | 1 | Reset command (pulse) |
| rd_strobe | input | 1 | A read access happens this cycle |
| alg_done | input | 1 | Internal algorithm completed |
| array_data | input | 8 | Byte read from the array |
| rd_data | output | 8 | Byte returned to the host |
| erase_mask | output | SECTORS | Sectors selected for erase |

## Verification
Two of the block's functions can land in the same cycle, and the bench forces each collision on purpose.

The first collision is between a sector-erase command and the closing of the acceptance window. The bench waits exactly `WIN_CYCLES-1` cycles after a sector command, then issues a second one. It judges the result by three things: the new mask bit appears, `rd_data[3]` stays 0 for a fresh full window, and only then does it rise.

The second collision is between completion and timeout. The bench raises `alg_done` on the cycle the program limit expires. It then expects array data rather than a set bit 5.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int SECTORS     = 8,
  parameter int WIN_CYCLES  = 8,
  parameter int PROG_LIMIT  = 20,
  parameter int ERASE_LIMIT = 40,
  localparam int SECT_W = $clog2(SECTORS),
  localparam int WIN_W  = $clog2(WIN_CYCLES + 1),
  localparam int OP_MAX = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT,
  localparam int OP_W   = $clog2(OP_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_prog,
  input  logic               cmd_chip_erase,
  input  logic               cmd_sector_erase,
  input  logic [SECT_W-1:0]  cmd_sector,
  input  logic               cmd_reset,
  input  logic               rd_strobe,
  input  logic               alg_done,
  input  logic [7:0]         array_data,
  output logic [7:0]         rd_data,
  output logic [SECTORS-1:0] erase_mask
);

  typedef enum logic [2:0] {ST_IDLE, ST_PROG, ST_WIN, ST_ERASE, ST_FAIL} st_t;

  st_t              st;
  logic             tog;
  logic [WIN_W-1:0] win_cnt;
  logic [OP_W-1:0]  op_cnt;
  logic [OP_W-1:0]  op_lim;
  logic [SECTORS-1:0] sect_bit;

  assign sect_bit = SECTORS'(1) << cmd_sector;
  assign op_lim   = (st == ST_PROG) ? OP_W'(PROG_LIMIT - 1) : OP_W'(ERASE_LIMIT - 1);

  assign rd_data = (st == ST_IDLE) ? array_data
                 : {1'b0, tog, st == ST_FAIL, 1'b0, st == ST_ERASE, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      tog        <= 1'b0;
      erase_mask <= '0;
      win_cnt    <= '0;
      op_cnt     <= '0;
    end else begin
      if (rd_strobe && st != ST_IDLE) tog <= ~tog;
      case (st)
        ST_IDLE: begin
          tog <= 1'b0;
          if (cmd_prog) begin
            st     <= ST_PROG;
            op_cnt <= '0;
          end else if (cmd_chip_erase) begin
            st         <= ST_ERASE;
            erase_mask <= '1;
            op_cnt     <= '0;
          end else if (cmd_sector_erase) begin
            st         <= ST_WIN;
            erase_mask <= sect_bit;
            win_cnt    <= '0;
          end
        end
        ST_WIN: begin
          if (cmd_sector_erase) begin
            erase_mask <= erase_mask | sect_bit;
            win_cnt    <= '0;
          end else if (win_cnt == WIN_W'(WIN_CYCLES - 1)) begin
            st     <= ST_ERASE;
            op_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_PROG, ST_ERASE: begin
          if (alg_done) begin
            st         <= ST_IDLE;
            erase_mask <= '0;
            tog        <= 1'b0;
          end else if (op_cnt == op_lim) begin
            st <= ST_FAIL;
          end else begin
            op_cnt <= op_cnt + 1'b1;
          end
        end
        ST_FAIL: begin
          if (cmd_reset) begin
            st         <= ST_IDLE;
            erase_mask <= '0;
            tog        <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAIL && !cmd_reset) |=> (st == ST_FAIL && rd_data[5]));

  // R9
  erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && !alg_done) |=> $stable(erase_mask));

  // R8
  win_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN) |=> ((erase_mask & $past(erase_mask)) == $past(erase_mask)));

  // R3
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && st == ST_WIN) |=> (rd_data[6] != $past(rd_data[6])));

  // R10
  op_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cnt < OP_W'(OP_MAX)) && (win_cnt < WIN_W'(WIN_CYCLES)));

endmodule

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
  localparam int SECTORS = 8, WIN = 8, PL = 20, EL = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_prog = 0, cmd_chip_erase = 0, cmd_sector_erase = 0, cmd_reset = 0;
  logic [2:0] cmd_sector = 0;
  logic rd_strobe = 0, alg_done = 0;
  logic [7:0] array_data = 8'hC3;
  logic [7:0] rd_data;
  logic [SECTORS-1:0] erase_mask;
  int vectors = 0, fails = 0;

  always #5 clk = ~clk;

  flash_status_gen #(.SECTORS(SECTORS), .WIN_CYCLES(WIN), .PROG_LIMIT(PL), .ERASE_LIMIT(EL)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_chip_erase(cmd_chip_erase),
    .cmd_sector_erase(cmd_sector_erase), .cmd_sector(cmd_sector), .cmd_reset(cmd_reset),
    .rd_strobe(rd_strobe), .alg_done(alg_done), .array_data(array_data),
    .rd_data(rd_data), .erase_mask(erase_mask));

  // cmd codes: 0 none, 1 program, 2 chip erase, 3 sector erase, 4 reset
  // fields: cmd[23:21] sect[20:18] done[17] rd[16] arr[15:8] exp[7:0]
  localparam logic [23:0] VEC [15] = '{
    {3'd0, 3'd0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {3'd0, 3'd0, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {3'd1, 3'd0, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {3'd0, 3'd0, 1'b0, 1'b1, 8'h3C, 8'h00},
    {3'd0, 3'd0, 1'b0, 1'b1, 8'h3C, 8'h40},
    {3'd0, 3'd0, 1'b0, 1'b0, 8'h3C, 8'h00},
    {3'd0, 3'd0, 1'b0, 1'b1, 8'h3C, 8'h00},
    {3'd0, 3'd0, 1'b0, 1'b0, 8'hFF, 8'h40},
    {3'd0, 3'd0, 1'b1, 1'b0, 8'hFF, 8'h40},
    {3'd0, 3'd0, 1'b0, 1'b0, 8'h5A, 8'h5A},
    {3'd2, 3'd0, 1'b0, 1'b0, 8'h5A, 8'h5A},
    {3'd0, 3'd0, 1'b0, 1'b1, 8'h5A, 8'h08},
    {3'd0, 3'd0, 1'b0, 1'b1, 8'h5A, 8'h48},
    {3'd0, 3'd0, 1'b1, 1'b0, 8'h5A, 8'h08},
    {3'd0, 3'd0, 1'b0, 1'b0, 8'h77, 8'h77}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [2:0] cmd, input logic [2:0] sect, input logic done, input logic rd);
    cmd_prog = (cmd == 3'd1);
    cmd_chip_erase = (cmd == 3'd2);
    cmd_sector_erase = (cmd == 3'd3);
    cmd_reset = (cmd == 3'd4);
    cmd_sector = sect;
    alg_done = done;
    rd_strobe = rd;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    drive(3'd0, 3'd0, 1'b0, 1'b0);
    #1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset rd_data", rd_data, 8'hC3);
    check("R1 reset mask", erase_mask, 8'h00);
    rst_n = 1'b1;
    tick(1);

    foreach (VEC[i]) begin
      drive(VEC[i][23:21], VEC[i][20:18], VEC[i][17], VEC[i][16]);
      array_data = VEC[i][15:8];
      #1;
      check(i < 2 ? "R2 idle" : (i < 9 ? "R3/R4/R5 program" : "R6 chip erase"), rd_data, VEC[i][7:0]);
      @(negedge clk);
    end
    drive(3'd0, 3'd0, 1'b0, 1'b0);
    array_data = 8'h96;

    // R7 single sector window
    drive(3'd3, 3'd1, 1'b0, 1'b0); tick(1);
    check("R7 window status", rd_data, 8'h00);
    check("R7 mask", erase_mask, 8'h02);
    tick(WIN - 1);
    check("R7 window still open", rd_data, 8'h00);
    tick(1);
    check("R7 erase begun", rd_data, 8'h08);
    // R9 commands ignored during erase
    cmd_sector_erase = 1; cmd_sector = 3'd6; cmd_prog = 1; cmd_reset = 1; tick(1);
    check("R9 mask unchanged", erase_mask, 8'h02);
    check("R9 status unchanged", rd_data, 8'h08);
    alg_done = 1; tick(1);
    check("R5 done to idle", rd_data, 8'h96);
    check("R5 mask cleared", erase_mask, 8'h00);

    // R8 extra sector in the last window cycle
    drive(3'd3, 3'd2, 1'b0, 1'b0); tick(1);
    tick(WIN - 1);
    drive(3'd3, 3'd5, 1'b0, 1'b0); tick(1);
    check("R8 mask added", erase_mask, 8'h24);
    check("R8 window restarted", rd_data, 8'h00);
    tick(WIN - 1);
    check("R8 window open late", rd_data, 8'h00);
    tick(1);
    check("R8 erase begun", rd_data, 8'h08);
    alg_done = 1; tick(1);

    // R10 / R11 program timeout
    drive(3'd1, 3'd0, 1'b0, 1'b0); tick(1);
    tick(PL - 1);
    check("R10 before limit", rd_data, 8'h00);
    tick(1);
    check("R10 program fail", rd_data, 8'h20);
    rd_strobe = 1; tick(1);
    check("R11 toggle in fail", rd_data, 8'h60);
    cmd_sector_erase = 1; cmd_sector = 3'd3; alg_done = 1; tick(1);
    check("R11 done/cmd ignored", rd_data, 8'h60);
    check("R11 mask unchanged", erase_mask, 8'h00);
    cmd_reset = 1; tick(1);
    check("R11 reset to array", rd_data, 8'h96);

    // R10 erase timeout
    drive(3'd2, 3'd0, 1'b0, 1'b0); tick(1);
    tick(EL - 1);
    check("R10 erase before limit", rd_data, 8'h08);
    tick(1);
    check("R10 erase fail", rd_data, 8'h20);
    check("R11 mask kept in fail", erase_mask, 8'hFF);
    cmd_reset = 1; tick(1);
    check("R11 reset clears mask", erase_mask, 8'h00);

    // R12 done on the limit cycle
    drive(3'd1, 3'd0, 1'b0, 1'b0); tick(1);
    tick(PL - 1);
    alg_done = 1; tick(1);
    check("R12 done beats timeout", rd_data, 8'h96);

    // R1 reset during an operation
    drive(3'd3, 3'd4, 1'b0, 1'b0); tick(1);
    rst_n = 0; tick(1);
    check("R1 reset mid-window", rd_data, 8'h96);
    check("R1 reset mid-window mask", erase_mask, 8'h00);
    rst_n = 1; tick(1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule